// File: doc/BRIEF.md
# Warp Issue Scheduler with Result-Latency Tracking

This block picks one warp at a time from a pool of resident warps and streams its instruction through a narrow datapath. A warp is 32 threads and the datapath is 8 lanes wide. A single-precision instruction therefore takes four back-to-back cycles, with one group of eight threads per cycle. A double-precision instruction goes through one shared unit, one thread per cycle, and holds the datapath for 32 cycles.

A result is usable 24 cycles after its instruction starts. The scheduler keeps a countdown for each warp. A warp that flags its next instruction as dependent is skipped until its countdown has expired, and independent warps fill the slots in the meantime. Warps are picked in round-robin order. With six dependent warps ready, each warp's turn comes round exactly when its previous result lands, so no issue slot is lost.

Block barriers are tracked per group of consecutive warps. A warp that reports arrival is held back until every valid warp of its group has arrived. Warps of other groups keep issuing.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset `ex_valid` and `ex_start` are 0, every latency countdown is 0 and the round-robin pointer is warp 0.
- R2: A single-precision instruction occupies exactly 4 consecutive cycles with `ex_phase` 0,1,2,3, the same `ex_warp`, and `ex_lane_grp` equal to `ex_phase`. `ex_start` is 1 only in the phase-0 cycle.
- R3: If an eligible warp exists in the last cycle of an instruction, or in an idle cycle, the next instruction starts in the following cycle.
- R4: A warp whose `warp_dep` bit is 1 never starts sooner than 24 cycles after its previous start.
- R5: A warp whose `warp_dep` bit is 0 may start regardless of its outstanding latency, so it can start 4 cycles after its own previous start.
- R6: The warp chosen is the first eligible warp at or after the warp following the last one issued, wrapping from the top index to 0. In a cycle with no issue the pointer does not move.
- R7: With warps 0 to 5 all valid, ready and dependent, the datapath is busy in every cycle, and the warps start in the order 0,1,2,3,4,5 repeating, 4 cycles apart.
- R8: A double-precision instruction (`warp_dp`=1) occupies 32 consecutive cycles with `ex_phase` 0 to 31, `ex_dp`=1 and `ex_lane_grp` equal to `ex_phase`/8.
- R9: Warps are grouped into barrier groups of 4 consecutive indices (warps 4..7 form group 1). A valid warp sampled with `bar_arrive`=1 does not issue at that edge or afterwards until every valid warp of its group has arrived. The release takes effect one edge after the last arrival, so the first start after release is visible two cycles after the last arrival edge. Warps of other groups are unaffected.
- R10: A warp with `warp_valid`=0 or `warp_ready`=0 never starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_valid | input | 24 | Warp slot holds a resident warp |
| warp_ready | input | 24 | Warp has an instruction ready to issue |
| warp_dep | input | 24 | Next instruction needs the warp's previous result |
| warp_dp | input | 24 | Next instruction is double precision |
| bar_arrive | input | 24 | Warp reaches the block barrier this cycle |
| ex_valid | output | 1 | Datapath is executing a warp this cycle |
| ex_start | output | 1 | First cycle of a newly issued instruction |
| ex_warp | output | 5 | Warp currently on the datapath |
| ex_lane_grp | output | 2 | Group of 8 threads handled this cycle |
| ex_phase | output | 5 | Cycle index within the current instruction |
| ex_dp | output | 1 | Current instruction is double precision |

## Verification
The decision is made at the edge where the flags are sampled, and `ex_start` appears in the cycle after that edge. The bench drives flags at the falling edge, samples 2 ns after the rising edge, and queues each expected start together with its gap from the previous start, or with its absolute cycle where the timing matters: the barrier release is due two edges after the last arrival. The dependency check is made separately, by comparing the cycle counts between starts of the same warp against 24. The idle count is taken over the exact window of edges during which the six dependent warps are presented.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // circular index step used by the round-robin search
  function automatic int unsigned wrap_inc(int unsigned base, int unsigned off, int unsigned n);
    return (base + off) % n;
  endfunction

  // final phase index of an instruction
  function automatic int unsigned last_phase(logic dp, int unsigned sp_cyc, int unsigned dp_cyc);
    return dp ? dp_cyc - 1 : sp_cyc - 1;
  endfunction

  // thread group served in a phase: SP covers one group per cycle,
  // the shared DP unit walks one thread per cycle
  function automatic int unsigned lane_grp_of(int unsigned ph, logic dp, int unsigned lanes);
    return dp ? ph / lanes : ph;
  endfunction

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N_WARPS = 24,
  localparam int WID_W = $clog2(N_WARPS)
) (
  input  logic [N_WARPS-1:0] elig,
  input  logic [WID_W-1:0]   ptr,
  output logic               found,
  output logic [WID_W-1:0]   idx
);
  import wis_pkg::*;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N_WARPS; i++) begin
      int unsigned j;
      j = wrap_inc(int'(ptr), i, N_WARPS);
      if (!found && elig[j]) begin
        found = 1'b1;
        idx   = WID_W'(j);
      end
    end
  end
endmodule

// File: rtl/wis_lat_track.sv
module wis_lat_track #(
  parameter int N_WARPS = 24,
  parameter int RES_LAT = 24,
  localparam int WID_W = $clog2(N_WARPS),
  localparam int CNT_W = $clog2(RES_LAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_now,
  input  logic [WID_W-1:0]   issue_idx,
  output logic [N_WARPS-1:0] pend
);
  for (genvar g = 0; g < N_WARPS; g++) begin : g_warp
    logic [CNT_W-1:0] remain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        remain <= '0;
      else if (issue_now && issue_idx == WID_W'(g))
        remain <= CNT_W'(RES_LAT - 1);
      else if (remain != '0)
        remain <= remain - 1'b1;
    end
    assign pend[g] = (remain != '0);
  end
endmodule

// File: rtl/wis_barrier.sv
module wis_barrier #(
  parameter int N_WARPS = 24,
  parameter int WARPS_PER_BLK = 4,
  localparam int N_BLK = (N_WARPS + WARPS_PER_BLK - 1) / WARPS_PER_BLK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WARPS-1:0] warp_valid,
  input  logic [N_WARPS-1:0] bar_arrive,
  output logic [N_WARPS-1:0] held
);
  logic [N_WARPS-1:0] arrived;
  logic [N_BLK-1:0]   blk_done;

  always_comb begin
    blk_done = '1;
    for (int w = 0; w < N_WARPS; w++)
      if (warp_valid[w] && !arrived[w]) blk_done[w / WARPS_PER_BLK] = 1'b0;
  end

  for (genvar g = 0; g < N_WARPS; g++) begin : g_arr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        arrived[g] <= 1'b0;
      else if (blk_done[g / WARPS_PER_BLK])
        arrived[g] <= 1'b0;
      else if (bar_arrive[g] && warp_valid[g])
        arrived[g] <= 1'b1;
    end
  end

  assign held = arrived;
endmodule

// File: rtl/wis_exec_seq.sv
module wis_exec_seq #(
  parameter int N_WARPS = 24,
  parameter int SP_CYC  = 4,
  parameter int DP_CYC  = 32,
  parameter int LANES   = 8,
  localparam int WID_W = $clog2(N_WARPS),
  localparam int PH_W  = $clog2(DP_CYC),
  localparam int LG_W  = $clog2(SP_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_now,
  input  logic [WID_W-1:0] issue_idx,
  input  logic             issue_dp,
  output logic             free_next,
  output logic             ex_valid,
  output logic             ex_start,
  output logic [WID_W-1:0] ex_warp,
  output logic [LG_W-1:0]  ex_lane_grp,
  output logic [PH_W-1:0]  ex_phase,
  output logic             ex_dp
);
  import wis_pkg::*;

  logic at_last;
  assign at_last   = ex_valid && (ex_phase == PH_W'(last_phase(ex_dp, SP_CYC, DP_CYC)));
  assign free_next = !ex_valid || at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_start <= 1'b0;
      ex_warp  <= '0;
      ex_phase <= '0;
      ex_dp    <= 1'b0;
    end else if (issue_now) begin
      ex_valid <= 1'b1;
      ex_start <= 1'b1;
      ex_warp  <= issue_idx;
      ex_phase <= '0;
      ex_dp    <= issue_dp;
    end else if (at_last) begin
      ex_valid <= 1'b0;
      ex_start <= 1'b0;
    end else if (ex_valid) begin
      ex_start <= 1'b0;
      ex_phase <= ex_phase + 1'b1;
    end
  end

  assign ex_lane_grp = LG_W'(lane_grp_of(int'(ex_phase), ex_dp, LANES));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int N_WARPS       = 24,
  parameter int WARPS_PER_BLK = 4,
  parameter int THREADS       = 32,
  parameter int LANES         = 8,
  parameter int RES_LAT       = 24,
  parameter int DP_CYC        = 32,
  localparam int SP_CYC = THREADS / LANES,
  localparam int WID_W  = $clog2(N_WARPS),
  localparam int PH_W   = $clog2(DP_CYC),
  localparam int LG_W   = $clog2(SP_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WARPS-1:0] warp_valid,
  input  logic [N_WARPS-1:0] warp_ready,
  input  logic [N_WARPS-1:0] warp_dep,
  input  logic [N_WARPS-1:0] warp_dp,
  input  logic [N_WARPS-1:0] bar_arrive,
  output logic               ex_valid,
  output logic               ex_start,
  output logic [WID_W-1:0]   ex_warp,
  output logic [LG_W-1:0]    ex_lane_grp,
  output logic [PH_W-1:0]    ex_phase,
  output logic               ex_dp
);
  import wis_pkg::*;

  // named internal events
  logic [N_WARPS-1:0] pend, held, elig;
  logic               pick_found, issue_now, free_next;
  logic [WID_W-1:0]   pick_idx, rr_ptr;

  assign elig      = warp_valid & warp_ready & ~held & ~bar_arrive & ~(warp_dep & pend);
  assign issue_now = free_next && pick_found;

  wis_rr_pick #(.N_WARPS(N_WARPS)) u_pick (
    .elig(elig), .ptr(rr_ptr), .found(pick_found), .idx(pick_idx)
  );

  wis_lat_track #(.N_WARPS(N_WARPS), .RES_LAT(RES_LAT)) u_lat (
    .clk(clk), .rst_n(rst_n), .issue_now(issue_now), .issue_idx(pick_idx), .pend(pend)
  );

  wis_barrier #(.N_WARPS(N_WARPS), .WARPS_PER_BLK(WARPS_PER_BLK)) u_bar (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .bar_arrive(bar_arrive), .held(held)
  );

  wis_exec_seq #(.N_WARPS(N_WARPS), .SP_CYC(SP_CYC), .DP_CYC(DP_CYC), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .issue_now(issue_now), .issue_idx(pick_idx),
    .issue_dp(warp_dp[pick_idx]), .free_next(free_next),
    .ex_valid(ex_valid), .ex_start(ex_start), .ex_warp(ex_warp),
    .ex_lane_grp(ex_lane_grp), .ex_phase(ex_phase), .ex_dp(ex_dp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_ptr <= '0;
    else if (issue_now)
      rr_ptr <= WID_W'(wrap_inc(int'(pick_idx), 1, N_WARPS));
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int N_WARPS = 24,
  parameter int RES_LAT = 24,
  parameter int SP_CYC  = 4,
  parameter int DP_CYC  = 32,
  localparam int WID_W = $clog2(N_WARPS),
  localparam int PH_W  = $clog2(DP_CYC),
  localparam int AGE_W = $clog2(RES_LAT + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_WARPS-1:0] warp_valid,
  input logic [N_WARPS-1:0] warp_ready,
  input logic [N_WARPS-1:0] warp_dep,
  input logic [N_WARPS-1:0] bar_arrive,
  input logic [N_WARPS-1:0] held,
  input logic               issue_now,
  input logic               pick_found,
  input logic [WID_W-1:0]   pick_idx,
  input logic [WID_W-1:0]   rr_ptr,
  input logic               ex_valid,
  input logic               ex_start,
  input logic [WID_W-1:0]   ex_warp,
  input logic [PH_W-1:0]    ex_phase,
  input logic               ex_dp
);
  logic [AGE_W-1:0] age [N_WARPS];
  logic             in_last;

  assign in_last = ex_phase == (ex_dp ? PH_W'(DP_CYC - 1) : PH_W'(SP_CYC - 1));

  for (genvar g = 0; g < N_WARPS; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age[g] <= AGE_W'(RES_LAT);
      else if (issue_now && pick_idx == WID_W'(g))
        age[g] <= '0;
      else if (age[g] != AGE_W'(RES_LAT))
        age[g] <= age[g] + 1'b1;
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ex_start |-> ex_valid && ex_phase == '0);  // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !in_last |=> ex_valid && !ex_start && ex_phase == $past(ex_phase) + PH_W'(1) && $stable(ex_warp));  // R2
  AST_SP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_dp |-> ex_phase < PH_W'(SP_CYC));  // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid || in_last) && pick_found |=> ex_start);  // R3
  AST_DEP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now && warp_dep[pick_idx] |-> age[pick_idx] >= AGE_W'(RES_LAT - 1));  // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_now |=> $stable(rr_ptr));  // R6
  AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now |-> !held[pick_idx] && !bar_arrive[pick_idx]);  // R9
  AST_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now |-> warp_valid[pick_idx] && warp_ready[pick_idx]);  // R10
endmodule

bind warp_issue_sched wis_checker #(
  .N_WARPS(N_WARPS), .RES_LAT(RES_LAT), .SP_CYC(SP_CYC), .DP_CYC(DP_CYC)
) u_chk (.*);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] warp_valid = '0, warp_ready = '0, warp_dep = '0, warp_dp = '0, bar_arrive = '0;
  logic         ex_valid, ex_start, ex_dp;
  logic [4:0]   ex_warp, ex_phase;
  logic [1:0]   ex_lane_grp;

  warp_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_ready(warp_ready),
    .warp_dep(warp_dep), .warp_dp(warp_dp), .bar_arrive(bar_arrive),
    .ex_valid(ex_valid), .ex_start(ex_start), .ex_warp(ex_warp),
    .ex_lane_grp(ex_lane_grp), .ex_phase(ex_phase), .ex_dp(ex_dp)
  );

  always #5 clk = ~clk;

  typedef struct { int w; bit dp; int gap; int ecyc; int rq; } exp_t;
  exp_t exq[$];

  int  nchk = 0, nerr = 0, cyc = 0, idle_cnt = 0;
  bit  win = 1'b0, mon_on = 1'b0, done = 1'b0;
  int  last_start [N];
  int  prev_start = -1;
  bit  act = 1'b0, cur_dp = 1'b0;
  int  cur_w = 0, exp_ph = 0;

  task automatic chk(bit ok, string msg, int actv, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", msg, actv, expv);
    end
  endtask

  task automatic push(int w, bit dp, int gap, int ecyc, int rq);
    exp_t e;
    e.w = w; e.dp = dp; e.gap = gap; e.ecyc = ecyc; e.rq = rq;
    exq.push_back(e);
  endtask

  task automatic drive(logic [N-1:0] v, logic [N-1:0] r, logic [N-1:0] d,
                       logic [N-1:0] p, logic [N-1:0] a);
    @(negedge clk);
    warp_valid = v; warp_ready = r; warp_dep = d; warp_dp = p; bar_arrive = a;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // monitor: compares every active cycle against the queued expectations
  initial begin
    for (int i = 0; i < N; i++) last_start[i] = -1;
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        if (win && !ex_valid) idle_cnt++;
        if (act && (!ex_valid || ex_start)) begin
          chk(exp_ph == (cur_dp ? 32 : 4), "R2/R8 instruction length", exp_ph, cur_dp ? 32 : 4);
          act = 1'b0;
        end
        if (ex_valid && ex_start) begin
          chk(ex_phase == 0, "R2 start phase", int'(ex_phase), 0);
          if (exq.size() == 0) begin
            chk(1'b0, "R10 unexpected start of warp", int'(ex_warp), -1);
          end else begin
            exp_t e;
            e = exq.pop_front();
            chk(int'(ex_warp) == e.w, $sformatf("R%0d issued warp", e.rq), int'(ex_warp), e.w);
            chk(ex_dp == e.dp, $sformatf("R%0d precision", e.rq), int'(ex_dp), int'(e.dp));
            if (e.gap >= 0)
              chk(cyc - prev_start == e.gap, $sformatf("R%0d start gap", e.rq), cyc - prev_start, e.gap);
            if (e.ecyc >= 0)
              chk(cyc == e.ecyc, $sformatf("R%0d start cycle", e.rq), cyc, e.ecyc);
          end
          if (warp_dep[ex_warp] && last_start[ex_warp] >= 0)  // R4
            chk(cyc - last_start[ex_warp] >= 24, "R4 dependent restart", cyc - last_start[ex_warp], 24);
          last_start[ex_warp] = cyc;
          prev_start = cyc;
          act = 1'b1; cur_w = int'(ex_warp); cur_dp = ex_dp; exp_ph = 1;
        end else if (ex_valid) begin
          chk(act && int'(ex_warp) == cur_w && int'(ex_phase) == exp_ph && ex_dp == cur_dp,
              "R2/R8 phase sequence", int'(ex_phase), exp_ph);
          exp_ph++;
        end
        if (ex_valid)  // R2 R8 lane group
          chk(int'(ex_lane_grp) == (ex_dp ? int'(ex_phase) / 8 : int'(ex_phase)),
              "R2/R8 lane group", int'(ex_lane_grp), ex_dp ? int'(ex_phase) / 8 : int'(ex_phase));
      end
    end
  end

  initial begin
    edges(100000);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, nothing issues with no flags
    chk(ex_valid == 1'b0, "R1 ex_valid after reset", int'(ex_valid), 0);
    chk(ex_start == 1'b0, "R1 ex_start after reset", int'(ex_start), 0);
    mon_on = 1'b1;
    edges(5);

    // R7: six dependent warps, continuous issue 0..5
    for (int k = 0; k < 18; k++) push(k % 6, 1'b0, k == 0 ? -1 : 4, -1, 7);
    drive(24'h3F, 24'h3F, 24'h3F, '0, '0);
    win = 1'b1; idle_cnt = 0;
    edges(72);
    drive('0, '0, '0, '0, '0);
    win = 1'b0;
    chk(idle_cnt == 0, "R7 idle cycles in steady state", idle_cnt, 0);
    edges(40);

    // R4: a lone dependent warp restarts every 24 cycles
    push(2, 1'b0, -1, -1, 4);
    push(2, 1'b0, 24, -1, 4);
    drive(24'h4, 24'h4, 24'h4, '0, '0);
    edges(48);
    drive('0, '0, '0, '0, '0);
    edges(10);

    // R5/R6: dependent warp 2 mixed with independent warp 7, pointer now 3
    begin
      int seq [12] = '{7, 2, 7, 7, 7, 7, 7, 2, 7, 7, 7, 7};
      for (int k = 0; k < 12; k++) push(seq[k], 1'b0, k == 0 ? -1 : 4, -1, 5);
    end
    drive(24'h84, 24'h84, 24'h4, '0, '0);
    edges(48);
    drive('0, '0, '0, '0, '0);
    edges(10);

    // R6: wrap-around order from pointer 8 over warps 1,5,9
    begin
      int seq [6] = '{9, 1, 5, 9, 1, 5};
      for (int k = 0; k < 6; k++) push(seq[k], 1'b0, k == 0 ? -1 : 4, -1, 6);
    end
    drive(24'h222, 24'h222, '0, '0, '0);
    edges(24);
    drive('0, '0, '0, '0, '0);
    edges(10);

    // R8: double precision warp 3 alternating with single precision warp 4
    push(3, 1'b1, -1, -1, 8);
    push(4, 1'b0, 32, -1, 8);
    push(3, 1'b1, 4, -1, 8);
    drive(24'h18, 24'h18, '0, 24'h8, '0);
    edges(40);
    drive('0, '0, '0, '0, '0);
    edges(50);

    // R9/R10: warps 4..6 wait at the barrier, warp 8 keeps going, warp 9 invalid
    drive(24'h1F0, '0, '0, '0, 24'h070);
    drive(24'h1F0, '0, '0, '0, '0);
    for (int k = 0; k < 4; k++) push(8, 1'b0, k == 0 ? -1 : 4, -1, 9);
    drive(24'h1F0, 24'h370, '0, '0, '0);
    edges(16);
    drive(24'h1F0, '0, '0, '0, '0);
    edges(10);
    drive(24'h1F0, '0, '0, '0, 24'h080);   // last arrival of group 1
    drive(24'h1F0, 24'h070, '0, '0, '0);
    push(4, 1'b0, -1, cyc + 2, 9);
    push(5, 1'b0, 4, -1, 9);
    push(6, 1'b0, 4, -1, 9);
    edges(12);
    drive('0, '0, '0, '0, '0);
    edges(20);

    chk(exq.size() == 0, "R6 expected starts left over", exq.size(), 0);
    chk(ex_valid == 1'b0, "R10 idle with no ready warps", int'(ex_valid), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule